// File: doc/BRIEF.md
# Vector Immediate-Offset Address Sequencer

This block turns one vectorised load or store with an immediate offset into a stream of effective addresses, one per cycle. A start pulse captures the context: the vector length, the source and destination predicate masks, a signed immediate, the access width, and flags for a vector or scalar base, a vector or scalar destination, and the update register. From then on the sequencer walks its source, destination and update indices. It reads base values through a small element-read port, and offers each address on a valid/ready handshake together with the destination element index and an optional update-register write.

The addressing style is chosen from the context. A vector base gives per-element bases. A scalar base uses unit stride when the stride-select flag is clear. It uses element stride when the flag is set and the immediate is nonzero. It repeats one address (splat) when the flag is set and the immediate is zero. The sequence ends, with a one-cycle done pulse, when any active index scan runs past the vector length, or right after the first accepted address when the destination is scalar.

Top module: `vlsu_addr_seq`

## Requirements
- R1: After reset `addr_valid_o` and `done_o` are low, and they stay low until a start pulse arrives.
- R2: With a vector base, the source index skips elements whose `src_mask_i` bit is 0. The address is `base[i]` plus the sign-extended immediate, and `base_idx_o` carries `i`.
- R3: With a scalar base and `stride_sel_i`=0, the address is base + imm + k·bytes. `width_i` codes 0,1,2,3 mean 1,2,4,8 bytes.
- R4: With a scalar base, `stride_sel_i`=1 and a nonzero immediate, the address is base + k·imm. Here k is the stride index: the source index for loads (`store_i`=0) and the destination index for stores (`store_i`=1). With a scalar base the source index counts accesses and does not skip.
- R5: With a scalar base, `stride_sel_i`=1 and a zero immediate, every element gets the same address, the base.
- R6: With a vector destination, `dst_idx_o` skips elements whose `dst_mask_i` bit is 0. With a scalar destination, `dst_idx_o` is 0 and the sequence ends after the first accepted address.
- R7: The sequence ends when the source index, the destination index or, if update is enabled, the update index reaches `vl_i`. `done_o` then pulses for one cycle with no address valid. A vector length of 0 gives no addresses.
- R8: With `upd_en_i`=1 every address comes with `upd_we_o`=1. `upd_idx_o` skips zero `src_mask_i` bits when `upd_vec_i`=1, and stays 0 otherwise.
- R9: While `addr_valid_o` is high and `addr_ready_i` is low, the address, destination index and update outputs hold. Exactly one element advances per accepted handshake.
- R10: Address arithmetic is 64 bits wide and wraps modulo 2^64. The immediate is sign-extended.
- R11: A start pulse that arrives while a sequence is in progress is ignored, and the running sequence's addresses are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start a sequence (taken only when idle) |
| vl_i | input | IW (5) | Vector length, 0..MAX_VL |
| src_mask_i | input | MAX_VL (16) | Source predicate mask |
| dst_mask_i | input | MAX_VL (16) | Destination predicate mask |
| base_vec_i | input | 1 | Base is a vector (per-element bases) |
| dst_vec_i | input | 1 | Destination is a vector |
| upd_en_i | input | 1 | Write each address to the update register |
| upd_vec_i | input | 1 | Update register is a vector |
| stride_sel_i | input | 1 | Scalar base: 0 unit stride, 1 element stride or splat |
| store_i | input | 1 | Operation is a store |
| imm_i | input | IMM_W (16) | Signed immediate |
| width_i | input | 2 | Access width code, bytes = 1 << code |
| base_idx_o | output | IW (5) | Element index of the base value to read |
| base_data_i | input | AW (64) | Base value for `base_idx_o`, combinational |
| addr_valid_o | output | 1 | Address valid |
| addr_ready_i | input | 1 | Consumer accepts the address |
| addr_o | output | AW (64) | Effective address |
| dst_idx_o | output | IW (5) | Destination element index |
| upd_we_o | output | 1 | Update-register write for this address |
| upd_idx_o | output | IW (5) | Update-register element index |
| done_o | output | 1 | One-cycle end-of-sequence pulse |

## Verification
The hold check on a stalled address assumes that `base_data_i` is a pure function of `base_idx_o` and does not change during a sequence. It also assumes that `vl_i` never exceeds `MAX_VL`. The bench keeps its base table fixed while a sequence runs, changes it only between sequences, and never uses a vector length above 16. The stimulus drives `addr_ready_i` always high in some sequences and from a pseudo-random pattern in others, so that stalls land on many element positions. It also pulses start in the middle of a long sequence.

// File: rtl/vlsu_seq_pkg.sv
package vlsu_seq_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DONE} seq_state_e;
  typedef enum logic [1:0] {AM_ELEM_BASE, AM_UNIT, AM_STRIDE, AM_SPLAT} addr_mode_e;
endpackage

// File: rtl/vlsu_idx_scan.sv
// First index >= start_i with a set mask bit; N when none. Pass-through when skip is off.
module vlsu_idx_scan #(
  parameter int N  = 16,
  parameter int IW = $clog2(N + 1)
) (
  input  logic [N-1:0]  mask_i,
  input  logic [IW-1:0] start_i,
  input  logic          skip_i,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    logic found;
    found = 1'b0;
    idx_o = start_i;
    if (skip_i) begin
      idx_o = IW'(N);
      for (int b = 0; b < N; b++) begin
        if (!found && (b >= int'(start_i)) && mask_i[b]) begin
          idx_o = IW'(b);
          found = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/vlsu_ea_calc.sv
module vlsu_ea_calc
  import vlsu_seq_pkg::*;
#(
  parameter int AW    = 64,
  parameter int IMM_W = 16,
  parameter int IW    = 5
) (
  input  addr_mode_e     mode_i,
  input  logic [AW-1:0]  base_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic [1:0]     width_i,
  input  logic [IW-1:0]  step_i,
  output logic [AW-1:0]  addr_o
);
  logic [AW-1:0] imm_x;
  logic [AW-1:0] step_x;

  assign imm_x  = {{(AW-IMM_W){imm_i[IMM_W-1]}}, imm_i};
  assign step_x = AW'(step_i);

  always_comb begin
    unique case (mode_i)
      AM_ELEM_BASE: addr_o = base_i + imm_x;
      AM_UNIT:      addr_o = base_i + imm_x + (step_x << width_i);
      AM_STRIDE:    addr_o = base_i + step_x * imm_x;
      default:      addr_o = base_i;
    endcase
  end
endmodule

// File: rtl/vlsu_addr_seq.sv
module vlsu_addr_seq
  import vlsu_seq_pkg::*;
#(
  parameter int MAX_VL = 16,
  parameter int AW     = 64,
  parameter int IMM_W  = 16,
  localparam int IW    = $clog2(MAX_VL + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [IW-1:0]     vl_i,
  input  logic [MAX_VL-1:0] src_mask_i,
  input  logic [MAX_VL-1:0] dst_mask_i,
  input  logic              base_vec_i,
  input  logic              dst_vec_i,
  input  logic              upd_en_i,
  input  logic              upd_vec_i,
  input  logic              stride_sel_i,
  input  logic              store_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic [1:0]        width_i,
  output logic [IW-1:0]     base_idx_o,
  input  logic [AW-1:0]     base_data_i,
  output logic              addr_valid_o,
  input  logic              addr_ready_i,
  output logic [AW-1:0]     addr_o,
  output logic [IW-1:0]     dst_idx_o,
  output logic              upd_we_o,
  output logic [IW-1:0]     upd_idx_o,
  output logic              done_o
);
  seq_state_e state_q;
  logic [IW-1:0]     vl_q, i_q, j_q, u_q;
  logic [MAX_VL-1:0] smask_q, dmask_q;
  logic              bv_q, dv_q, ue_q, uv_q, ss_q, st_q;
  logic [IMM_W-1:0]  imm_q;
  logic [1:0]        w_q;

  logic [IW-1:0] i_eff, j_eff, u_eff, step;
  logic          ended, accept;
  addr_mode_e    mode;

  vlsu_idx_scan #(.N(MAX_VL), .IW(IW)) u_scan_src (
    .mask_i(smask_q), .start_i(i_q), .skip_i(bv_q), .idx_o(i_eff));
  vlsu_idx_scan #(.N(MAX_VL), .IW(IW)) u_scan_dst (
    .mask_i(dmask_q), .start_i(j_q), .skip_i(dv_q), .idx_o(j_eff));
  vlsu_idx_scan #(.N(MAX_VL), .IW(IW)) u_scan_upd (
    .mask_i(smask_q), .start_i(u_q), .skip_i(uv_q), .idx_o(u_eff));

  always_comb begin
    if (bv_q)             mode = AM_ELEM_BASE;
    else if (!ss_q)       mode = AM_UNIT;
    else if (imm_q != '0) mode = AM_STRIDE;
    else                  mode = AM_SPLAT;
  end

  assign step = st_q ? j_eff : i_eff;

  vlsu_ea_calc #(.AW(AW), .IMM_W(IMM_W), .IW(IW)) u_ea (
    .mode_i(mode), .base_i(base_data_i), .imm_i(imm_q), .width_i(w_q),
    .step_i(step), .addr_o(addr_o));

  assign ended        = (i_eff >= vl_q) || (j_eff >= vl_q) || (ue_q && (u_eff >= vl_q));
  assign addr_valid_o = (state_q == ST_RUN) && !ended;
  assign accept       = addr_valid_o && addr_ready_i;
  assign base_idx_o   = bv_q ? i_eff : '0;
  assign dst_idx_o    = j_eff;
  assign upd_we_o     = addr_valid_o && ue_q;
  assign upd_idx_o    = u_eff;
  assign done_o       = (state_q == ST_DONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      vl_q <= '0; i_q <= '0; j_q <= '0; u_q <= '0;
      smask_q <= '0; dmask_q <= '0;
      bv_q <= 1'b0; dv_q <= 1'b0; ue_q <= 1'b0; uv_q <= 1'b0;
      ss_q <= 1'b0; st_q <= 1'b0; imm_q <= '0; w_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_RUN;
          vl_q <= vl_i; smask_q <= src_mask_i; dmask_q <= dst_mask_i;
          bv_q <= base_vec_i; dv_q <= dst_vec_i; ue_q <= upd_en_i; uv_q <= upd_vec_i;
          ss_q <= stride_sel_i; st_q <= store_i; imm_q <= imm_i; w_q <= width_i;
          i_q <= '0; j_q <= '0; u_q <= '0;
        end
        ST_RUN: begin
          if (ended) state_q <= ST_DONE;
          else if (accept) begin
            if (!dv_q) state_q <= ST_DONE;
            i_q <= i_eff + IW'(1);
            j_q <= j_eff + IW'(1);
            if (uv_q) u_q <= u_eff + IW'(1);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // stalled address must not move (base read port assumed stable)
  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_valid_o && !addr_ready_i |=> addr_valid_o && $stable(addr_o) && $stable(dst_idx_o)
      && $stable(upd_idx_o));
  assert_scalar_stop_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_valid_o && addr_ready_i && !dv_q |=> done_o);
  assert_dst_pred_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_valid_o && dv_q |-> (((dmask_q >> dst_idx_o) & MAX_VL'(1)) != '0));
  assert_upd_pred_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_we_o && uv_q |-> (((smask_q >> upd_idx_o) & MAX_VL'(1)) != '0));
  assert_done_excl_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({addr_valid_o, done_o}));
  assert_done_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && !addr_valid_o);
endmodule

// File: tb/vlsu_addr_seq_tb.sv
`timescale 1ns/1ps
module vlsu_addr_seq_tb;
  localparam int MAXV = 16;
  localparam int IW   = 5;

  typedef struct packed {
    logic [63:0]   addr;
    logic [IW-1:0] dst;
    logic          we;
    logic [IW-1:0] uidx;
  } exp_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0;
  logic [IW-1:0] vl = '0;
  logic [MAXV-1:0] sm = '0, dm = '0;
  logic bv = 0, dv = 0, ue = 0, uv = 0, ss = 0, st = 0;
  logic [15:0] imm = '0;
  logic [1:0] w = '0;
  logic [IW-1:0] base_idx;
  logic [63:0] base_data;
  logic valid, ready = 1'b1;
  logic [63:0] addr;
  logic [IW-1:0] dst_idx, upd_idx;
  logic upd_we, done;

  logic [63:0] base_tbl [0:MAXV];
  exp_t q[$];
  int total = 0, bad = 0;
  string cur_tag = "R1";
  int rdy_mode = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #2 clk = ~clk;

  always_comb base_data = (int'(base_idx) <= MAXV) ? base_tbl[base_idx] : 64'd0;

  vlsu_addr_seq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .vl_i(vl),
    .src_mask_i(sm), .dst_mask_i(dm), .base_vec_i(bv), .dst_vec_i(dv),
    .upd_en_i(ue), .upd_vec_i(uv), .stride_sel_i(ss), .store_i(st),
    .imm_i(imm), .width_i(w), .base_idx_o(base_idx), .base_data_i(base_data),
    .addr_valid_o(valid), .addr_ready_i(ready), .addr_o(addr),
    .dst_idx_o(dst_idx), .upd_we_o(upd_we), .upd_idx_o(upd_idx), .done_o(done));

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ready pattern, changed just after each rising edge
  always @(posedge clk) begin
    #1;
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    ready <= (rdy_mode == 0) ? 1'b1 : lfsr[3];
  end

  // monitor: pops expected items on each handshake, checks stalls hold
  initial begin
    exp_t held, e;
    logic pend;
    pend = 1'b0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (pend) begin
          check("R9 stall hold", {63'd0, valid}, 64'd1);
          if (valid) check("R9 stall hold", {addr, 54'd0, dst_idx, upd_idx},
                           {held.addr, 54'd0, held.dst, held.uidx});
        end
        pend = 1'b0;
        if (valid) begin
          if (ready) begin
            if (q.size() == 0) begin
              check({cur_tag, " extra address"}, addr, 64'hDEAD);
            end else begin
              e = q.pop_front();
              check({cur_tag, " addr"}, addr, e.addr);
              check({cur_tag, " dst_idx"}, 64'(dst_idx), 64'(e.dst));
              check({cur_tag, " upd"}, {58'd0, upd_we, upd_idx}, {58'd0, e.we, e.uidx});
            end
          end else begin
            pend = 1'b1;
            held.addr = addr; held.dst = dst_idx; held.uidx = upd_idx; held.we = upd_we;
          end
        end
      end
    end
  end

  // reference sequence from the requirements
  task automatic build_expected();
    int i = 0, j = 0, u = 0, k;
    logic [63:0] b, ix, a;
    ix = {{48{imm[15]}}, imm};
    while (1) begin
      if (bv) while (i < MAXV && !sm[i]) i++;
      if (dv) while (j < MAXV && !dm[j]) j++;
      if (uv) while (u < MAXV && !sm[u]) u++;
      if (i >= int'(vl) || j >= int'(vl) || (ue && u >= int'(vl))) break;
      k = st ? j : i;
      b = base_tbl[bv ? i : 0];
      if (bv)              a = b + ix;
      else if (!ss)        a = b + ix + 64'(k) * (64'd1 << w);
      else if (imm != '0)  a = b + 64'(k) * ix;
      else                 a = b;
      q.push_back('{addr: a, dst: IW'(j), we: ue, uidx: IW'(u)});
      if (!dv) break;
      i++; j++;
      if (uv) u++;
    end
  endtask

  task automatic run_case(string tag, int n, logic [15:0] smask, logic [15:0] dmask,
                          logic b_v, logic d_v, logic u_e, logic u_v, logic s_s,
                          logic s_t, logic [15:0] im, logic [1:0] wc, int rmode,
                          bit mid_start);
    int cyc;
    @(posedge clk); #1;
    cur_tag = tag; rdy_mode = rmode;
    vl = IW'(n); sm = smask; dm = dmask; bv = b_v; dv = d_v; ue = u_e; uv = u_v;
    ss = s_s; st = s_t; imm = im; w = wc;
    q.delete();
    build_expected();
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    if (mid_start) begin
      @(posedge clk); #1;
      start = 1'b1; vl = IW'(1); imm = 16'h0100; // R11: must be ignored
      @(posedge clk); #1;
      start = 1'b0;
    end
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (!done && cyc < 400);
    check({tag, " done seen"}, {63'd0, done}, 64'd1);
    check({tag, " all addresses issued"}, 64'(q.size()), 64'd0);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int k = 0; k <= MAXV; k++) base_tbl[k] = 64'h1000_0000 + 64'(k) * 64'h130;
    repeat (3) @(negedge clk);
    check("R1 valid in reset", {63'd0, valid}, 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 valid idle", {63'd0, valid}, 64'd0);
    check("R1 done idle", {63'd0, done}, 64'd0);

    // R2 / R10 per-element base, negative immediate, src holes
    run_case("R2", 10, 16'hB5F2, 16'hFFFF, 1, 1, 0, 0, 0, 0, 16'hFFF8, 2'd3, 0, 0);
    // R3 unit stride across all widths
    for (int wc = 0; wc < 4; wc++)
      run_case("R3", 5, 16'hFFFF, 16'hFFFF, 0, 1, 0, 0, 0, 0, 16'd4, 2'(wc), 0, 0);
    // R4 element stride: loads step on source, stores on destination
    run_case("R4 load", 6, 16'hFFFF, 16'h00F6, 0, 1, 0, 0, 1, 0, 16'd24, 2'd2, 0, 0);
    run_case("R4 store", 6, 16'hFFFF, 16'h00F6, 0, 1, 0, 0, 1, 1, 16'd24, 2'd2, 0, 0);
    run_case("R4 neg", 4, 16'hFFFF, 16'hFFFF, 0, 1, 0, 0, 1, 0, 16'hFFF0, 2'd0, 0, 0);
    // R5 splat
    run_case("R5", 7, 16'hFFFF, 16'hFFFF, 0, 1, 0, 0, 1, 0, 16'd0, 2'd3, 0, 0);
    // R6 scalar destination: one access at first active source
    run_case("R6 scalar", 8, 16'h00F4, 16'h0000, 1, 0, 0, 0, 0, 0, 16'd2, 2'd0, 0, 0);
    run_case("R6 skip", 12, 16'hFFFF, 16'h5A5A, 1, 1, 0, 0, 0, 0, 16'd0, 2'd0, 0, 0);
    // R7 empty and exhausted sequences
    run_case("R7 vl0", 0, 16'hFFFF, 16'hFFFF, 0, 1, 0, 0, 0, 0, 16'd8, 2'd1, 0, 0);
    run_case("R7 nodst", 4, 16'hFFFF, 16'hFF00, 0, 1, 0, 0, 0, 0, 16'd8, 2'd1, 0, 0);
    run_case("R7 src", 16, 16'h000F, 16'hFFFF, 1, 1, 0, 0, 0, 0, 16'd1, 2'd0, 0, 0);
    // R8 update register vector and scalar
    run_case("R8 vec", 14, 16'h6DB7, 16'hFFFF, 0, 1, 1, 1, 0, 0, 16'd16, 2'd3, 0, 0);
    run_case("R8 scal", 5, 16'hFFFF, 16'hFFFF, 1, 1, 1, 0, 0, 0, 16'd3, 2'd2, 0, 0);
    // R9 random backpressure
    run_case("R9 bv", 16, 16'hEFF7, 16'hFBDF, 1, 1, 1, 1, 0, 0, 16'h8000, 2'd1, 1, 0);
    run_case("R9 unit", 16, 16'hFFFF, 16'hFFFF, 0, 1, 0, 0, 0, 1, 16'd12, 2'd2, 1, 0);
    // R10 wrap modulo 2^64
    base_tbl[0] = 64'hFFFF_FFFF_FFFF_FFF0;
    run_case("R10", 4, 16'hFFFF, 16'hFFFF, 0, 1, 0, 0, 0, 0, 16'd0, 2'd3, 0, 0);
    base_tbl[0] = 64'h1000_0000;
    // R11 start pulse mid-sequence ignored
    run_case("R11", 16, 16'hFFFF, 16'hFFFF, 0, 1, 0, 0, 1, 0, 16'd40, 2'd0, 1, 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule